// File: doc/BRIEF.md
# Processor Pin Event Controller

This block sits between the external control and interrupt pins of a processor and the core's interrupt and run-control logic. Each cycle it compares the sampled pin vector with a registered copy of the previous levels and acts only on pins whose level has actually changed. Each known pin has its own kind: an active-high level source, an active-low level control, or a falling-edge source. Holding a pin at the same level produces no further event.

Three active-high level sources (external interrupt, system-management interrupt, debug) and one falling-edge source (machine check) feed a four-bit pending mask, and a combined interrupt request is raised while any pending bit is set. The machine-check bit is latched: it stays set after its pin returns high, and only an acknowledge pulse from the core clears it. Control pins drive a halt request, one-cycle core-reset and system-reset request pulses, and a time-base enable level. Pins with no assigned function are ignored.

Top module: `pin_irq_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the pending mask, interrupt request, halt, both reset pulses and the time-base enable are all 0. Reset loads the previous-level copy with the inactive level of each pin: 0 for active-high pins, 1 for active-low and falling-edge pins.
- R2: Pending bits 0 (external, pin 0), 1 (system-management, pin 1) and 2 (debug, pin 2) follow their pin one clock after the level changes: 1 sets the bit, 0 clears it.
- R3: Pending bit 3 (machine check, pin 3) is set one clock after a 1-to-0 change of pin 3. A rising edge does not clear it, so the bit stays set after the pin returns high.
- R4: A high `mck_ack_i` during a clock edge clears pending bit 3, unless a falling edge of pin 3 is seen in the same cycle. In that case the bit stays set.
- R5: `irq_o` is 1 one clock after any pending bit becomes set. It returns to 0 only after the whole pending mask is zero.
- R6: Pin 4 low sets `halt_o` one clock later. With `HALT_RESTART` = 1, pin 4 returning high clears `halt_o`. With `HALT_RESTART` = 0, `halt_o` stays set until reset.
- R7: A 1-to-0 change of pin 5 gives a one-cycle pulse on `sys_rst_o` one clock later. Holding the pin low gives no further pulse.
- R8: A 1-to-0 change of pin 6 gives a one-cycle pulse on `core_rst_o` one clock later. Holding the pin low gives no further pulse.
- R9: `tb_en_o` follows pin 7 (active high) one clock after the pin changes.
- R10: Pins at indices outside the assigned set (8 and 9 by default) have no effect on any output.
- R11: A pin held at the same level generates no new event. Machine check held low after an acknowledge does not set pending bit 3 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS | Pin levels, already synchronized to clk |
| mck_ack_i | input | 1 | Core acknowledge of the machine-check source |
| pend_o | output | 4 | Pending mask: bit 0 external, 1 system-management, 2 debug, 3 machine check |
| irq_o | output | 1 | Combined interrupt request |
| halt_o | output | 1 | Halt request to the core |
| core_rst_o | output | 1 | One-cycle core-reset request |
| sys_rst_o | output | 1 | One-cycle system-reset request |
| tb_en_o | output | 1 | Time-base enable |

## Verification
The bench builds the block twice from the same pin stimulus. Both builds use the default ten-pin width, which leaves pins 8 and 9 unmapped so that the ignored-pin rule can be exercised. One build uses `HALT_RESTART` = 1 and the other uses 0, so both halt behaviours are checked from the same sequence. The bench also releases reset while the machine-check and halt pins are already low. This shows that the inactive reset values of the previous-level copy turn those low pins into events.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;
   // slot order of the gathered known-pin vector
   localparam int K_EXT  = 0;
   localparam int K_SMI  = 1;
   localparam int K_DBG  = 2;
   localparam int K_MCK  = 3;
   localparam int K_HALT = 4;
   localparam int K_HRST = 5;
   localparam int K_CRST = 6;
   localparam int K_TBEN = 7;
   localparam int NK     = 8;

   // number of active-high level sources feeding the pending mask
   localparam int N_LVL  = 3;
   localparam int PEND_W = N_LVL + 1;
   localparam int PB_MCK = N_LVL;

   // inactive level per slot: machine check, halt and both resets idle high
   localparam logic [NK-1:0] K_IDLE = (NK'(1) << K_MCK) | (NK'(1) << K_HALT)
                                    | (NK'(1) << K_HRST) | (NK'(1) << K_CRST);
endpackage

// File: rtl/pinctl_sampler.sv
module pinctl_sampler #(
   parameter int              W    = 8,
   parameter logic [W-1:0]    IDLE = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   output logic [W-1:0] rise_o,
   output logic [W-1:0] fall_o
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE;
      else        prev_q <= lvl_i;
   end

   for (genvar b = 0; b < W; b++) begin : g_det
      assign rise_o[b] =  lvl_i[b] & ~prev_q[b];
      assign fall_o[b] = ~lvl_i[b] &  prev_q[b];
   end
endmodule

// File: rtl/pinctl_pending.sv
module pinctl_pending
   import pinctl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_LVL-1:0]  lvl_rise_i,
   input  logic [N_LVL-1:0]  lvl_fall_i,
   input  logic              mck_fall_i,
   input  logic              mck_ack_i,
   output logic [PEND_W-1:0] pend_o,
   output logic              irq_o
);
   logic [PEND_W-1:0] pend_q, pend_d;
   logic              irq_q;

   for (genvar s = 0; s < N_LVL; s++) begin : g_lvl
      always_comb begin
         pend_d[s] = pend_q[s];
         if (lvl_rise_i[s])      pend_d[s] = 1'b1;
         else if (lvl_fall_i[s]) pend_d[s] = 1'b0;
      end
   end

   // a fresh falling edge outranks a same-cycle acknowledge
   always_comb begin
      pend_d[PB_MCK] = pend_q[PB_MCK];
      if (mck_fall_i)     pend_d[PB_MCK] = 1'b1;
      else if (mck_ack_i) pend_d[PB_MCK] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         pend_q <= pend_d;
         irq_q  <= |pend_d;
      end
   end

   assign pend_o = pend_q;
   assign irq_o  = irq_q;
endmodule

// File: rtl/pinctl_runctl.sv
module pinctl_runctl #(
   parameter bit HALT_RESTART = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic halt_fall_i,
   input  logic halt_rise_i,
   input  logic hrst_fall_i,
   input  logic crst_fall_i,
   input  logic tb_rise_i,
   input  logic tb_fall_i,
   output logic halt_o,
   output logic sys_rst_o,
   output logic core_rst_o,
   output logic tb_en_o
);
   logic halt_q, halt_clr;
   logic sys_q, core_q, tb_q;

   if (HALT_RESTART) begin : g_restart
      assign halt_clr = halt_rise_i;
   end else begin : g_sticky
      logic unused_halt_rise;
      assign unused_halt_rise = halt_rise_i;
      assign halt_clr = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q <= 1'b0;
         sys_q  <= 1'b0;
         core_q <= 1'b0;
         tb_q   <= 1'b0;
      end else begin
         if (halt_fall_i)   halt_q <= 1'b1;
         else if (halt_clr) halt_q <= 1'b0;
         sys_q  <= hrst_fall_i;
         core_q <= crst_fall_i;
         if (tb_rise_i)      tb_q <= 1'b1;
         else if (tb_fall_i) tb_q <= 1'b0;
      end
   end

   assign halt_o     = halt_q;
   assign sys_rst_o  = sys_q;
   assign core_rst_o = core_q;
   assign tb_en_o    = tb_q;
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
   import pinctl_pkg::*;
#(
   parameter int NUM_PINS     = 10,
   parameter int PIN_EXT      = 0,
   parameter int PIN_SMI      = 1,
   parameter int PIN_DBG      = 2,
   parameter int PIN_MCK      = 3,
   parameter int PIN_HALT     = 4,
   parameter int PIN_HRST     = 5,
   parameter int PIN_CRST     = 6,
   parameter int PIN_TBEN     = 7,
   parameter bit HALT_RESTART = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pins_i,
   input  logic                mck_ack_i,
   output logic [PEND_W-1:0]   pend_o,
   output logic                irq_o,
   output logic                halt_o,
   output logic                core_rst_o,
   output logic                sys_rst_o,
   output logic                tb_en_o
);
   localparam int PIN_MAP [NK] = '{PIN_EXT, PIN_SMI, PIN_DBG, PIN_MCK,
                                   PIN_HALT, PIN_HRST, PIN_CRST, PIN_TBEN};

   function automatic logic [NUM_PINS-1:0] mapped_mask();
      logic [NUM_PINS-1:0] m = '0;
      for (int k = 0; k < NK; k++)
         if (PIN_MAP[k] >= 0 && PIN_MAP[k] < NUM_PINS) m[PIN_MAP[k]] = 1'b1;
      return m;
   endfunction

   localparam logic [NUM_PINS-1:0] MAPPED = mapped_mask();

   if (NUM_PINS < NK) begin : g_err_width
      $error("pin_irq_ctrl: NUM_PINS must cover all %0d assigned functions", NK);
   end
   if ($countones(MAPPED) != NK) begin : g_err_map
      $error("pin_irq_ctrl: pin indices must be distinct and below NUM_PINS");
   end

   logic [NK-1:0] kp, k_rise, k_fall;

   for (genvar k = 0; k < NK; k++) begin : g_gather
      assign kp[k] = pins_i[PIN_MAP[k]];
   end

   // pins without a function are deliberately left unconsumed
   logic unused_pins;
   assign unused_pins = ^(pins_i & ~MAPPED);

   pinctl_sampler #(.W(NK), .IDLE(K_IDLE)) u_smp (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (kp),
      .rise_o (k_rise),
      .fall_o (k_fall)
   );

   logic unused_edges;
   assign unused_edges = k_rise[K_MCK] ^ k_rise[K_HRST] ^ k_rise[K_CRST];

   pinctl_pending u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_rise_i (k_rise[N_LVL-1:0]),
      .lvl_fall_i (k_fall[N_LVL-1:0]),
      .mck_fall_i (k_fall[K_MCK]),
      .mck_ack_i  (mck_ack_i),
      .pend_o     (pend_o),
      .irq_o      (irq_o)
   );

   pinctl_runctl #(.HALT_RESTART(HALT_RESTART)) u_run (
      .clk         (clk),
      .rst_n       (rst_n),
      .halt_fall_i (k_fall[K_HALT]),
      .halt_rise_i (k_rise[K_HALT]),
      .hrst_fall_i (k_fall[K_HRST]),
      .crst_fall_i (k_fall[K_CRST]),
      .tb_rise_i   (k_rise[K_TBEN]),
      .tb_fall_i   (k_fall[K_TBEN]),
      .halt_o      (halt_o),
      .sys_rst_o   (sys_rst_o),
      .core_rst_o  (core_rst_o),
      .tb_en_o     (tb_en_o)
   );
endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] lvl_pins,
   input logic       mck_pin,
   input logic       halt_pin,
   input logic       tben_pin,
   input logic       mck_ack_i,
   input logic [3:0] pend_o,
   input logic       halt_o,
   input logic       sys_rst_o,
   input logic       core_rst_o,
   input logic       tb_en_o
);
   p_lvl_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> pend_o[2:0] == $past(lvl_pins));

   p_mck_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mck_pin) |=> pend_o[3]);

   p_mck_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o[3] && !mck_ack_i) |=> pend_o[3]);

   p_halt_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !halt_pin |=> halt_o);

   p_sys_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_o |=> !sys_rst_o);

   p_core_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst_o |=> !core_rst_o);

   p_tb_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> tb_en_o == $past(tben_pin));
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lvl_pins   ({pins_i[PIN_DBG], pins_i[PIN_SMI], pins_i[PIN_EXT]}),
   .mck_pin    (pins_i[PIN_MCK]),
   .halt_pin   (pins_i[PIN_HALT]),
   .tben_pin   (pins_i[PIN_TBEN]),
   .mck_ack_i  (mck_ack_i),
   .pend_o     (pend_o),
   .halt_o     (halt_o),
   .sys_rst_o  (sys_rst_o),
   .core_rst_o (core_rst_o),
   .tb_en_o    (tb_en_o)
);

// File: tb/tb_pin_irq_ctrl.sv
module tb_pin_irq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] pins = 10'h078;
   logic       ack = 1'b0;

   logic [3:0] pend, s_pend;
   logic       irq, halt, crst, srst, tben;
   logic       s_irq, s_halt, s_crst, s_srst, s_tben;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   pin_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .mck_ack_i(ack),
      .pend_o(pend), .irq_o(irq), .halt_o(halt),
      .core_rst_o(crst), .sys_rst_o(srst), .tb_en_o(tben));

   pin_irq_ctrl #(.HALT_RESTART(1'b0)) dut_sticky (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .mck_ack_i(ack),
      .pend_o(s_pend), .irq_o(s_irq), .halt_o(s_halt),
      .core_rst_o(s_crst), .sys_rst_o(s_srst), .tb_en_o(s_tben));

   typedef struct packed {
      logic [9:0] pins;
      logic       ack;
      logic [8:0] exp;   // {pend, irq, halt, crst, srst, tben}
      logic [3:0] rq;
   } row_t;

   localparam int NROW = 32;
   localparam row_t TBL [NROW] = '{
      '{10'h078, 1'b0, 9'b0000_0_0_0_0_0, 4'd1},   // R1 idle
      '{10'h079, 1'b0, 9'b0001_1_0_0_0_0, 4'd2},   // R2 ext up
      '{10'h07B, 1'b0, 9'b0011_1_0_0_0_0, 4'd2},   // R2 smi up
      '{10'h07A, 1'b0, 9'b0010_1_0_0_0_0, 4'd5},   // R5 ext down, irq held
      '{10'h07E, 1'b0, 9'b0110_1_0_0_0_0, 4'd2},   // R2 debug up
      '{10'h078, 1'b0, 9'b0000_0_0_0_0_0, 4'd5},   // R5 mask empty
      '{10'h070, 1'b0, 9'b1000_1_0_0_0_0, 4'd3},   // R3 mck fall
      '{10'h078, 1'b0, 9'b1000_1_0_0_0_0, 4'd3},   // R3 mck rise keeps
      '{10'h078, 1'b1, 9'b0000_0_0_0_0_0, 4'd4},   // R4 ack clears
      '{10'h070, 1'b0, 9'b1000_1_0_0_0_0, 4'd3},   // R3 fall again
      '{10'h070, 1'b1, 9'b0000_0_0_0_0_0, 4'd4},   // R4 ack, pin held low
      '{10'h070, 1'b0, 9'b0000_0_0_0_0_0, 4'd11},  // R11 no re-trigger
      '{10'h078, 1'b0, 9'b0000_0_0_0_0_0, 4'd3},   // R3 rise ignored
      '{10'h070, 1'b1, 9'b1000_1_0_0_0_0, 4'd4},   // R4 fall beats ack
      '{10'h078, 1'b1, 9'b0000_0_0_0_0_0, 4'd4},   // R4
      '{10'h068, 1'b0, 9'b0000_0_1_0_0_0, 4'd6},   // R6 halt low
      '{10'h068, 1'b0, 9'b0000_0_1_0_0_0, 4'd6},   // R6
      '{10'h078, 1'b0, 9'b0000_0_0_0_0_0, 4'd6},   // R6 restart
      '{10'h058, 1'b0, 9'b0000_0_0_0_1_0, 4'd7},   // R7 system reset pulse
      '{10'h058, 1'b0, 9'b0000_0_0_0_0_0, 4'd7},   // R7 held, no pulse
      '{10'h078, 1'b0, 9'b0000_0_0_0_0_0, 4'd7},   // R7
      '{10'h038, 1'b0, 9'b0000_0_0_1_0_0, 4'd8},   // R8 core reset pulse
      '{10'h038, 1'b0, 9'b0000_0_0_0_0_0, 4'd8},   // R8 held
      '{10'h078, 1'b0, 9'b0000_0_0_0_0_0, 4'd8},   // R8
      '{10'h0F8, 1'b0, 9'b0000_0_0_0_0_1, 4'd9},   // R9 time base on
      '{10'h0F8, 1'b0, 9'b0000_0_0_0_0_1, 4'd9},   // R9
      '{10'h078, 1'b0, 9'b0000_0_0_0_0_0, 4'd9},   // R9 frozen
      '{10'h378, 1'b0, 9'b0000_0_0_0_0_0, 4'd10},  // R10 unmapped high
      '{10'h278, 1'b0, 9'b0000_0_0_0_0_0, 4'd10},  // R10
      '{10'h078, 1'b0, 9'b0000_0_0_0_0_0, 4'd10},  // R10
      '{10'h0F9, 1'b0, 9'b0001_1_0_0_0_1, 4'd2},   // R2 with R9
      '{10'h078, 1'b0, 9'b0000_0_0_0_0_0, 4'd9}
   };

   function automatic logic [8:0] outs();
      return {pend, irq, halt, crst, srst, tben};
   endfunction

   function automatic logic [8:0] s_outs();
      return {s_pend, s_irq, s_halt, s_crst, s_srst, s_tben};
   endfunction

   task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic step(logic [9:0] p, logic a);
      @(negedge clk);
      pins = p;
      ack  = a;
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset held", outs(), 9'b0);
      check("R1 reset held sticky", s_outs(), 9'b0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NROW; i++) begin
         step(TBL[i].pins, TBL[i].ack);
         check($sformatf("R%0d row %0d", TBL[i].rq, i), outs(), TBL[i].exp);
      end

      // sticky variant kept halt from the earlier low pulse
      check("R6 sticky halt", {8'b0, s_halt}, 9'd1);

      // reset released while machine check and halt pins already low
      @(negedge clk);
      rst_n = 1'b0;
      pins  = 10'h060;
      ack   = 1'b0;
      @(posedge clk);
      #1;
      check("R1 reset clears", outs(), 9'b0);
      check("R1 reset clears sticky", s_outs(), 9'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R3 low at release", outs(), 9'b1000_1_1_0_0_0);
      check("R6 low at release sticky", s_outs(), 9'b1000_1_1_0_0_0);

      step(10'h078, 1'b1);
      check("R6 restart after release", outs(), 9'b0);
      check("R6 sticky stays", s_outs(), 9'b0000_0_1_0_0_0);
      step(10'h078, 1'b0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule